// File: doc/BRIEF.md
# Absolute Position Serial Readout Register

This block hands an absolute, Gray-coded position word to a host controller over a three-wire serial link. The host drives a level-sensitive capture/shift control and a serial clock. While the control is high, the register keeps taking the current parallel position word and the output shows its top bit. When the control drops, the word is frozen. Each rising edge of the serial clock then moves the word one place towards the output, top bit first. The host reads the output while the serial clock is low, or on its falling edge. It may stop after any number of clocks to take a shorter, coarser word.

Data on the serial input enters at the empty end of the register. A second encoder's output can therefore be chained behind this one, or the output can be fed back to form a ring. An optional direction input flips the top bit of every captured word, which reverses the counting sense.

The serial clock, control and data inputs are asynchronous to the block. Each one passes through a flop synchronizer into a system clock that runs at least four times faster than the serial clock, and an edge detector turns serial clock rises into one-cycle shift strobes.

Top module: `enc_serial_readout`

## Requirements
- R1: While `rst_n` is low, `sdout` is 0 and the register holds all zeros.
- R2: While `ld_mode` is 1, the register recaptures `pos_word` on every system clock. Three system clocks after the inputs settle, `sdout` equals the top bit of the captured word.
- R3: While `ld_mode` is 0, each rising edge of `sclk` advances the register by one place, top first. After the k-th rise (k from 1 to 15), `sdout` equals bit 15-k of the captured word.
- R4: Once `ld_mode` has fallen, changes on `pos_word` do not affect the bits shifted out until `ld_mode` is raised again.
- R5: In shift mode, `sdout` holds its value on system clocks with no `sclk` rise. Falling edges of `sclk` and `pos_word` changes have no effect.
- R6: The value on `sdin` at the n-th `sclk` rise is moved into the empty end of the register. It appears on `sdout` after the (n+15)-th rise, 16 places behind the local word.
- R7: When `msb_flip` is 1, bit 15 of the captured word is inverted and bits 14 to 0 are kept as they are. When it is 0, the word is captured unchanged.
- R8: A frame cut short after fewer than 16 rises yields that many leading bits. Raising `ld_mode` again starts the next frame from a fresh capture.
- R9: The `ld_mode`, `sclk` and `sdin` inputs are synchronized through two flops. A change in the register appears on `sdout` on the third system clock edge after `sclk` rises, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_word | input | 16 | Parallel Gray-coded position word, system clock domain |
| ld_mode | input | 1 | 1 = capture mode, 0 = shift mode (asynchronous) |
| sclk | input | 1 | Serial clock from the host; shifts on rising edges (asynchronous) |
| sdin | input | 1 | Serial data into the tail of the register (asynchronous) |
| msb_flip | input | 1 | 1 = invert the top bit of the captured word |
| sdout | output | 1 | Serial data out, top bit of the register |

## Verification
The assertions check four things on every cycle: that capture mode presents the captured top bit, that a shift strobe moves the next-lower bit to the output, that the register is frozen when there is neither capture nor strobe, and that strobes last exactly one cycle. Other behaviours depend on a whole frame and can only be shown by the bench's scenarios. These are the full bit order of a frame, the 16-place delay of tail data in a ring, the effect of a short frame, the top-bit inversion across random words, and the exact synchronizer latency.

// File: rtl/enc_ser_pkg.sv
package enc_ser_pkg;

   typedef enum logic {
      MODE_SHIFT = 1'b0,
      MODE_LOAD  = 1'b1
   } ser_mode_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < enc_ser_pkg::MIN_SYNC_STAGES)
         $error("enc_sync: STAGES must be at least 2");
      if (WIDTH < 1)
         $error("enc_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= '0;
               else        chain[gi] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= '0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/enc_rise_det.sv
module enc_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign pulse = lvl & ~lvl_q;
endmodule

// File: rtl/enc_shift_core.sv
module enc_shift_core
   import enc_ser_pkg::*;
#(
   parameter int unsigned WORD_W  = 16,
   parameter bit          FLIP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ser_mode_e         mode,
   input  logic              shift_en,
   input  logic [WORD_W-1:0] par_word,
   input  logic              flip,
   input  logic              ser_in,
   output logic [WORD_W-1:0] shreg
);
   initial begin
      if (WORD_W < 2)
         $error("enc_shift_core: WORD_W must be at least 2");
   end

   localparam int unsigned TOP = WORD_W - 1;

   logic [WORD_W-1:0] cap_word;

   generate
      if (FLIP_EN) begin : g_flip
         assign cap_word = {par_word[TOP] ^ flip, par_word[TOP-1:0]};
      end else begin : g_plain
         logic unused_flip;
         assign unused_flip = flip;
         assign cap_word    = par_word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (mode == MODE_LOAD) begin
         shreg <= cap_word;
      end else if (shift_en) begin
         shreg <= {shreg[TOP-1:0], ser_in};
      end
   end
endmodule

// File: rtl/enc_serial_readout.sv
module enc_serial_readout
   import enc_ser_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          FLIP_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] pos_word,
   input  logic              ld_mode,
   input  logic              sclk,
   input  logic              sdin,
   input  logic              msb_flip,
   output logic              sdout
);
   initial begin
      if (WORD_W < 2)
         $error("enc_serial_readout: WORD_W must be at least 2");
      if (SYNC_STAGES < MIN_SYNC_STAGES)
         $error("enc_serial_readout: SYNC_STAGES too small");
   end

   localparam int unsigned N_ASYNC = 3;

   logic [N_ASYNC-1:0] async_in;
   logic [N_ASYNC-1:0] sync_out;
   logic               ld_s;
   logic               sclk_s;
   logic               sdin_s;
   logic               shift_en;
   ser_mode_e          mode;
   logic [WORD_W-1:0]  shreg;

   assign async_in = {ld_mode, sclk, sdin};

   enc_sync #(
      .WIDTH  (N_ASYNC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (async_in),
      .q     (sync_out)
   );

   assign {ld_s, sclk_s, sdin_s} = sync_out;
   assign mode = ld_s ? MODE_LOAD : MODE_SHIFT;

   enc_rise_det u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sclk_s),
      .pulse (shift_en)
   );

   enc_shift_core #(
      .WORD_W  (WORD_W),
      .FLIP_EN (FLIP_EN)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .shift_en (shift_en),
      .par_word (pos_word),
      .flip     (msb_flip),
      .ser_in   (sdin_s),
      .shreg    (shreg)
   );

   assign sdout = shreg[WORD_W-1];
endmodule

// File: rtl/enc_serial_readout_chk.sv
module enc_serial_readout_chk #(
   parameter int unsigned WORD_W  = 16,
   parameter bit          FLIP_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_s,
   input logic              shift_en,
   input logic [WORD_W-1:0] shreg,
   input logic              pos_msb,
   input logic              msb_flip,
   input logic              sdout
);
   // R2 and R7: capture mode presents the captured top bit, inverted when asked
   assert_load_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_s |=> (sdout == ($past(pos_msb) ^ ($past(msb_flip) & FLIP_EN))));

   // R3: a shift strobe moves the next-lower bit to the output
   assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_s && shift_en) |=> (sdout == $past(shreg[WORD_W-2])));

   // R4 and R5: with neither capture nor strobe the register is frozen
   assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_s && !shift_en) |=> $stable(shreg));

   // R9: a serial clock rise yields a one-cycle strobe
   assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> !shift_en);
endmodule

bind enc_serial_readout enc_serial_readout_chk #(
   .WORD_W  (WORD_W),
   .FLIP_EN (FLIP_EN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_s     (ld_s),
   .shift_en (shift_en),
   .shreg    (shreg),
   .pos_msb  (pos_word[WORD_W-1]),
   .msb_flip (msb_flip),
   .sdout    (sdout)
);

// File: tb/enc_serial_readout_tb.sv
module enc_serial_readout_tb;
   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] pos_word = '0;
   logic         ld_mode = 1'b1;
   logic         sclk = 1'b0;
   logic         sdin = 1'b0;
   logic         msb_flip = 1'b0;
   logic         sdout;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   enc_serial_readout #(.WORD_W(W)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pos_word (pos_word),
      .ld_mode  (ld_mode),
      .sclk     (sclk),
      .sdin     (sdin),
      .msb_flip (msb_flip),
      .sdout    (sdout)
   );

   function automatic logic [W-1:0] frame_word(input logic [W-1:0] w, input logic f);
      return {w[W-1] ^ f, w[W-2:0]};
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one frame: capture, then nclk serial clock rises with random tail data
   task automatic run_frame(input logic [W-1:0] w, input logic f, input int nclk);
      logic [W-1:0] fw;
      logic         din_hist [64];
      logic         prev;
      logic         exp;
      fw = frame_word(w, f);
      @(negedge clk);
      ld_mode  = 1'b1;
      sclk     = 1'b0;
      pos_word = w;
      msb_flip = f;
      wait_clk(6);
      check(f ? "R7" : "R2", sdout, fw[W-1]);
      ld_mode = 1'b0;
      wait_clk(6);
      for (int k = 1; k <= nclk; k++) begin
         sdin = 1'($urandom);
         din_hist[k] = sdin;
         wait_clk(4);
         prev = sdout;
         sclk = 1'b1;
         pos_word = $urandom;   // R4: must not reach the frame
         exp = (k < W) ? fw[W-1-k] : din_hist[k-W+1];
         wait_clk(2);
         if (prev != exp) check("R9", sdout, prev);
         wait_clk(1);
         if (k < W) check(k == 1 && f ? "R7" : "R3/R4", sdout, exp);
         else       check("R6", sdout, exp);
         wait_clk(1);
         sclk = 1'b0;
      end
      // R5: idle, falling edge already given, word changes
      prev = sdout;
      for (int i = 0; i < 8; i++) begin
         pos_word = $urandom;
         @(negedge clk);
      end
      check("R5", sdout, prev);
   endtask

   initial begin
      void'($urandom(32'd7421));
      wait_clk(3);
      check("R1", sdout, 1'b0);
      rst_n = 1'b1;
      // R2: capture mode follows the word
      pos_word = 16'h8001;
      wait_clk(5);
      check("R2", sdout, 1'b1);
      pos_word = 16'h7FFF;
      wait_clk(5);
      check("R2", sdout, 1'b0);
      // directed frames
      run_frame(16'hA5C3, 1'b0, 16);
      run_frame(16'h0F0F, 1'b1, 16);   // R7
      run_frame(16'hFFFF, 1'b1, 16);   // R7
      run_frame(16'h1234, 1'b0, 12);   // R8 short frame
      run_frame(16'h5A5A, 1'b0, 13);   // R8 short frame
      run_frame(16'hC0DE, 1'b0, 40);   // R6 ring / cascade
      for (int t = 0; t < 30; t++)
         run_frame(16'($urandom), 1'($urandom), 1 + ($urandom % 36));
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule